// File: doc/BRIEF.md
# Serial Adder Self-Test Sequencer

This block is a synthesizable built-in self-test controller for a bit-serial adder. It steps through a small set of stored operand pairs. For each pair it holds the adder in reset while it presents the operands. It then releases the reset and pulses a start strobe. It waits a fixed number of clock cycles, two per operand bit, for the serial result. It then compares the adder's sum with a parallel reference sum of its own, computed as an (N+1)-bit value.

A level-sensitive run request lets the sequence advance out of its loading state. The controller counts the completed tests internally. Any mismatch latches a sticky failure flag. After the last pair the controller parks in a terminal state and raises done. The pass output tells a surrounding test wrapper whether every pair matched.

Top module: `sadd_bist_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `done_o`, `fail_o`, `pass_o` and `add_start_o` are 0, `add_rst_n_o` is 0, and the operands show pair 0.
- R2: In the loading state the adder reset `add_rst_n_o` is driven 0 and the operands of the current pair are presented. While `run_i` is low the sequencer stays there and never pulses `add_start_o`.
- R3: With `run_i` high, the cycle after a loading cycle releases `add_rst_n_o` to 1 and pulses `add_start_o` for exactly one cycle.
- R4: The wait lasts exactly 2*W cycles, counting the start cycle, followed by one compare cycle. Consecutive start pulses are therefore 2*W+2 cycles apart.
- R5: Pairs 0, 1 and 2 are A=B=4'b1011, A=B=4'b1100 and A=B=4'b0110, applied in index order. For an index i of 3 or more, or when W is not 4, A=(5i+3) mod 2^W and B=(3i+1) mod 2^W.
- R6: In the compare cycle, the W+1-bit input `add_sum_i` is compared with A+B including the carry-out. Any difference in any bit, the carry bit included, sets `fail_o`.
- R7: `fail_o` is sticky and is cleared only by reset.
- R8: After the compare of the last pair (index NUM_TESTS-1), `done_o` rises 2*W+1 cycles after that pair's start pulse. While done is held, `add_start_o` is 0, `add_rst_n_o` is 0 and both operands are 0, and this lasts until reset.
- R9: `pass_o` is 1 exactly when `done_o` is 1 and `fail_o` is 0.
- R10: The operands stay stable for as long as the adder reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run request; lets each test leave the loading state |
| add_a_o | output | W | Operand A to the serial adder |
| add_b_o | output | W | Operand B to the serial adder |
| add_start_o | output | 1 | One-cycle start strobe to the adder |
| add_rst_n_o | output | 1 | Active-low reset to the adder |
| add_sum_i | input | W+1 | Result of the adder, with carry-out in the top bit |
| pass_o | output | 1 | All tests finished with no mismatch |
| fail_o | output | 1 | Sticky mismatch flag |
| done_o | output | 1 | All tests finished |

## Verification
The failure path cannot be reached with a correct adder. The bench therefore pairs the sequencer with a behavioural serial adder that can be told to corrupt the carry bit of one chosen test. Runs are made with no fault, with a fault in a middle test and with a fault in the last test. These runs show where the flag rises, that it stays set, that a later reset clears it, and that a fault in the last test is still caught before done. A scoreboard compares every start pulse with the expected operands and with the expected spacing in cycles.

// File: rtl/sadd_bist_pkg.sv
package sadd_bist_pkg;

   typedef enum logic [1:0] {
      ST_LOAD  = 2'd0,
      ST_RUN   = 2'd1,
      ST_CMP   = 2'd2,
      ST_FIN   = 2'd3
   } seq_state_e;

   // Fixed seed patterns for a 4-bit adder; index 0..2
   function automatic logic [3:0] seed_nibble(input int unsigned idx);
      logic [3:0] v;
      case (idx)
         0:       v = 4'b1011;
         1:       v = 4'b1100;
         2:       v = 4'b0110;
         default: v = 4'b0000;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/seq_vec_store.sv
module seq_vec_store #(
   parameter int W  = 4,
   parameter int NT = 3,
   parameter int IW = 2
) (
   input  logic [IW-1:0] idx_i,
   output logic [W-1:0]  a_o,
   output logic [W-1:0]  b_o
);
   import sadd_bist_pkg::*;

   localparam int NSEED = 3;

   logic [31:0] idx_w;
   logic [31:0] gen_a;
   logic [31:0] gen_b;

   assign idx_w = 32'(idx_i);
   assign gen_a = idx_w * 32'd5 + 32'd3;
   assign gen_b = idx_w * 32'd3 + 32'd1;

   generate
      if (W == 4) begin : g_seeded
         always_comb begin
            if (idx_w < NSEED) begin
               a_o = W'(seed_nibble(idx_w));
               b_o = W'(seed_nibble(idx_w));
            end else begin
               a_o = gen_a[W-1:0];
               b_o = gen_b[W-1:0];
            end
         end
      end else begin : g_computed
         assign a_o = gen_a[W-1:0];
         assign b_o = gen_b[W-1:0];
      end
   endgenerate

   initial begin
      if (NT < 1)
         $error("seq_vec_store: NT must be at least 1");
      if ((1 << IW) < NT)
         $error("seq_vec_store: index width too small");
   end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
   parameter int W  = 4,
   parameter int NT = 3,
   parameter int IW = 2,
   parameter int CW = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run_i,
   output sadd_bist_pkg::seq_state_e state_o,
   output logic [IW-1:0]             idx_o,
   output logic                      start_o,
   output logic                      adder_rel_o,
   output logic                      cmp_o,
   output logic                      fin_o
);
   import sadd_bist_pkg::*;

   localparam logic [CW-1:0] LAST_CNT = CW'(2 * W - 1);
   localparam logic [IW-1:0] LAST_IDX = IW'(NT - 1);

   seq_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [IW-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_LOAD;
         cnt_q   <= '0;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_LOAD: begin
               if (run_i) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end
            end
            ST_RUN: begin
               if (cnt_q == LAST_CNT) begin
                  state_q <= ST_CMP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_CMP: begin
               if (idx_q == LAST_IDX) begin
                  state_q <= ST_FIN;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_LOAD;
               end
            end
            default: state_q <= ST_FIN;
         endcase
      end
   end

   assign state_o     = state_q;
   assign idx_o       = idx_q;
   assign start_o     = (state_q == ST_RUN) && (cnt_q == '0);
   assign adder_rel_o = (state_q == ST_RUN) || (state_q == ST_CMP);
   assign cmp_o       = (state_q == ST_CMP);
   assign fin_o       = (state_q == ST_FIN);

   initial begin
      if ((1 << CW) < 2 * W)
         $error("seq_ctrl: counter width too small");
   end
endmodule

// File: rtl/seq_ref_chk.sv
module seq_ref_chk #(
   parameter int W           = 4,
   parameter bit CARRY_CHECK = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmp_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W:0]   sum_i,
   output logic         fail_o
);
   logic mismatch;
   logic fail_q;

   generate
      if (CARRY_CHECK) begin : g_full
         logic [W:0] ref_sum;
         assign ref_sum  = {1'b0, a_i} + {1'b0, b_i};
         assign mismatch = (ref_sum != sum_i);
      end else begin : g_low
         logic [W-1:0] ref_low;
         assign ref_low  = a_i + b_i;
         assign mismatch = (ref_low != sum_i[W-1:0]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fail_q <= 1'b0;
      end else if (cmp_i && mismatch) begin
         fail_q <= 1'b1;
      end
   end

   assign fail_o = fail_q;
endmodule

// File: rtl/sadd_bist_seq.sv
module sadd_bist_seq #(
   parameter int W           = 4,
   parameter int NUM_TESTS   = 3,
   parameter bit CARRY_CHECK = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   output logic [W-1:0] add_a_o,
   output logic [W-1:0] add_b_o,
   output logic         add_start_o,
   output logic         add_rst_n_o,
   input  logic [W:0]   add_sum_i,
   output logic         pass_o,
   output logic         fail_o,
   output logic         done_o
);
   import sadd_bist_pkg::*;

   localparam int IW = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1;
   localparam int CW = $clog2(2 * W);

   seq_state_e   state;
   logic [IW-1:0] idx;
   logic [W-1:0]  vec_a;
   logic [W-1:0]  vec_b;
   logic          cmp;
   logic          fin;
   logic          rel;
   logic          fail;

   seq_ctrl #(.W(W), .NT(NUM_TESTS), .IW(IW), .CW(CW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run_i),
      .state_o     (state),
      .idx_o       (idx),
      .start_o     (add_start_o),
      .adder_rel_o (rel),
      .cmp_o       (cmp),
      .fin_o       (fin)
   );

   seq_vec_store #(.W(W), .NT(NUM_TESTS), .IW(IW)) u_vec (
      .idx_i (idx),
      .a_o   (vec_a),
      .b_o   (vec_b)
   );

   seq_ref_chk #(.W(W), .CARRY_CHECK(CARRY_CHECK)) u_ref (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmp_i  (cmp),
      .a_i    (vec_a),
      .b_i    (vec_b),
      .sum_i  (add_sum_i),
      .fail_o (fail)
   );

   assign add_a_o     = fin ? '0 : vec_a;
   assign add_b_o     = fin ? '0 : vec_b;
   assign add_rst_n_o = rel;
   assign fail_o      = fail;
   assign done_o      = fin;
   assign pass_o      = fin && !fail;

   initial begin
      if (W < 2)
         $error("sadd_bist_seq: W must be at least 2");
      if (NUM_TESTS < 1)
         $error("sadd_bist_seq: NUM_TESTS must be at least 1");
   end
endmodule

// File: rtl/sadd_bist_seq_chk.sv
module sadd_bist_seq_chk #(
   parameter int W = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         add_start_o,
   input logic         add_rst_n_o,
   input logic [W-1:0] add_a_o,
   input logic [W-1:0] add_b_o,
   input logic         pass_o,
   input logic         fail_o,
   input logic         done_o
);
   logic [15:0] gap;
   logic        seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (add_start_o) begin
         gap  <= 16'd1;
         seen <= 1'b1;
      end else if (gap != 16'hFFFF) begin
         gap <= gap + 16'd1;
      end
   end

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      add_start_o |=> !add_start_o); // R3
   AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      add_start_o |-> (add_rst_n_o && !$past(add_rst_n_o))); // R3
   AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (add_start_o && seen) |-> (gap == 16'(2 * W + 2))); // R4
   AST_DONE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !$past(done_o)) |-> (seen && gap == 16'(2 * W + 1))); // R8
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (done_o && !add_start_o && !add_rst_n_o)); // R8
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> fail_o); // R7
   AST_PASS_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> (done_o && !fail_o)); // R9
   AST_OPND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (add_rst_n_o && $past(add_rst_n_o)) |-> ($stable(add_a_o) && $stable(add_b_o))); // R10
endmodule

bind sadd_bist_seq sadd_bist_seq_chk #(.W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .add_start_o (add_start_o),
   .add_rst_n_o (add_rst_n_o),
   .add_a_o     (add_a_o),
   .add_b_o     (add_b_o),
   .pass_o      (pass_o),
   .fail_o      (fail_o),
   .done_o      (done_o)
);

// File: tb/tb_sadd_bist_seq.sv
`timescale 1ns/1ps
module tb_sadd_bist_seq;
   localparam int W  = 4;
   localparam int NT = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run = 1'b0;
   logic [W-1:0] a, b;
   logic         start, arst_n;
   logic [W:0]   sum_q;
   logic         pass, fail, done;

   int checks = 0;
   int errors = 0;
   int fault_sel = -1;

   always #5 clk = ~clk;

   sadd_bist_seq #(.W(W), .NUM_TESTS(NT)) dut (
      .clk(clk), .rst_n(rst_n), .run_i(run),
      .add_a_o(a), .add_b_o(b), .add_start_o(start), .add_rst_n_o(arst_n),
      .add_sum_i(sum_q), .pass_o(pass), .fail_o(fail), .done_o(done));

   // Behavioural serial adder with optional carry-bit corruption
   logic [W-1:0] sh_a, sh_b, res;
   logic         cy, busy;
   int           bitn, start_cnt, cur;
   always @(posedge clk) begin
      if (!rst_n) begin
         start_cnt <= 0;
      end
      if (!arst_n) begin
         sum_q <= '0; busy <= 1'b0; cy <= 1'b0; bitn <= 0; res <= '0;
      end else if (start) begin
         sh_a <= a; sh_b <= b; cy <= 1'b0; bitn <= 0; busy <= 1'b1;
         cur <= start_cnt; start_cnt <= start_cnt + 1;
      end else if (busy) begin
         logic s, co;
         s  = sh_a[0] ^ sh_b[0] ^ cy;
         co = (sh_a[0] & sh_b[0]) | (cy & (sh_a[0] ^ sh_b[0]));
         res  <= {s, res[W-1:1]};
         sh_a <= sh_a >> 1; sh_b <= sh_b >> 1; cy <= co;
         bitn <= bitn + 1;
         if (bitn == W - 1) begin
            busy  <= 1'b0;
            sum_q <= {co, s, res[W-1:1]} ^ ((cur == fault_sel) ? {1'b1, {W{1'b0}}} : '0);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_a(input int k);
      case (k)
         0: return 4'b1011;
         1: return 4'b1100;
         2: return 4'b0110;
         default: return W'(5 * k + 3);
      endcase
   endfunction

   typedef struct { logic [W-1:0] ea; logic [W-1:0] eb; bit fail_before; } item_t;
   item_t sb_q[$];

   // Monitor: pops one expected item per start pulse
   int  gap = 0;
   bit  has_prev = 0;
   bit  prev_done = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         has_prev = 0; gap = 0; prev_done = 0;
      end else begin
         gap++;
         if (start) begin
            if (has_prev) chk(gap == 2 * W + 2, "R4 start spacing", gap, 2 * W + 2);
            chk(arst_n == 1'b1, "R3 adder released at start", int'(arst_n), 1);
            if (sb_q.size() == 0) begin
               chk(1'b0, "R5 unexpected start", 1, 0);
            end else begin
               item_t it;
               it = sb_q.pop_front();
               chk(a == it.ea, "R5 operand A", int'(a), int'(it.ea));
               chk(b == it.eb, "R5 operand B", int'(b), int'(it.eb));
               chk(fail == it.fail_before, "R6 fail before test", int'(fail), int'(it.fail_before));
            end
            has_prev = 1; gap = 0;
         end
         if (done && !prev_done)
            chk(gap == 2 * W + 1, "R8 done delay", gap, 2 * W + 1);
         prev_done = done;
      end
   end

   // Driver: runs one full suite with a fault in test fsel (-1 for none)
   task automatic run_suite(input int fsel);
      run = 1'b0;
      rst_n = 1'b0;
      fault_sel = fsel;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!done && !fail && !pass && !start, "R1 status in reset", int'({done, fail, pass, start}), 0);
      chk(arst_n == 1'b0 && a == exp_a(0) && b == exp_a(0), "R1 adder held, pair 0",
          int'(a), int'(exp_a(0)));
      for (int k = 0; k < NT; k++) begin
         item_t it;
         it.ea = exp_a(k);
         it.eb = (k < 3) ? exp_a(k) : W'(3 * k + 1);
         it.fail_before = (fsel >= 0) && (k > fsel);
         sb_q.push_back(it);
      end
      rst_n = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk(!start && !arst_n, "R2 idle without run", int'({start, arst_n}), 0);
      end
      run = 1'b1;
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      chk(done == 1'b1, "R8 done reached", int'(done), 1);
      chk(fail == (fsel >= 0), "R6 fail result", int'(fail), int'(fsel >= 0));
      chk(pass == (fsel < 0), "R9 pass result", int'(pass), int'(fsel < 0));
      chk(sb_q.size() == 0, "R5 all pairs applied", sb_q.size(), 0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(done && !start && !arst_n && a == '0 && b == '0, "R8 terminal hold",
             int'({done, start, arst_n}), 4);
         chk(fail == (fsel >= 0), "R7 fail sticky", int'(fail), int'(fsel >= 0));
      end
      run = 1'b0;
   endtask

   initial begin
      run_suite(-1);
      run_suite(1);
      run_suite(2);
      run_suite(-1); // R7: reset clears the flag left by the previous run
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1ms;
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule